// File: doc/BRIEF.md
# Soft Mute Gain Ramp

This block sits in a stereo 24-bit sample path and multiplies both channels by a shared gain. The gain moves between unity and silence in small linear steps. A mute request input chooses the direction. The gain moves one step for every accepted sample, so the sample rate sets the pace. A full fade in either direction takes exactly 1024 sample periods.

If the request changes partway through a fade, the ramp turns around at the level it has reached. It then heads back the other way, and the gain never jumps. Once the gain reaches zero, both output channels carry exact zeros and a status flag reports the muted state.

An active-low power-down input holds the block in its reset condition while it is low. During that time the outputs are zero and no samples are accepted. When power-down is released, the gain starts again at unity.

Top module: `soft_mute_ramp`

## Requirements
- R1: After reset the outputs are zero, the output strobe is low, the muted flag is low and the attenuation level is 0 (unity gain).
- R2: At level 0 each accepted sample leaves unchanged one clock later, with the output strobe high for exactly that one cycle.
- R3: With the mute request high, every accepted sample raises the level by one, up to 1024. The muted flag is high exactly while the level is 1024, which is reached after 1024 accepted samples.
- R4: At level 1024 both output channels are exactly zero.
- R5: An accepted sample x at level a leaves as floor((x*(1024-a) + 512) / 1024), clipped to the signed 24-bit range.
- R6: With the mute request low, every accepted sample lowers the level by one, down to 0. A full return from level 1024 takes 1024 samples.
- R7: A change of the mute request in mid-ramp reverses the direction from the current level, without any jump in gain.
- R8: Cycles without an accepted sample leave the level and the outputs unchanged and keep the output strobe low.
- R9: While power-down is low, the outputs are zero, the strobe is low, the level returns to 0 and input samples are discarded.
- R10: Both channels of a sample are scaled by the same level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pdn_n | input | 1 | Power-down, active low; holds the block in its reset state |
| mute_req | input | 1 | High fades toward silence, low fades toward unity |
| in_valid | input | 1 | Input sample pair strobe, one per sample period |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| out_valid | output | 1 | Output sample pair strobe |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| muted | output | 1 | High while the gain is at full attenuation |

## Verification
The bench drives full-scale positive and negative samples and a spread of mixed-sign values through complete fades in both directions. It compares every output against a rounding model. This separates correct rounding and sign handling from truncation errors and from an off-by-one in the ramp length.

A reversal after 300 samples shows whether the ramp turns around at its current level or jumps. Gaps between strobes show whether the level advances per sample or per clock. Power-down in the middle of a fade checks that output zeroing works and that the level restarts at unity. Distinct left and right values show whether both channels share one gain.

// File: rtl/sm_pkg.sv
package sm_pkg;
    localparam int unsigned NCH = 2;

    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_DOWN = 2'd1,
        RAMP_UP   = 2'd2
    } ramp_dir_e;
endpackage

// File: rtl/sm_level_ctrl.sv
module sm_level_ctrl
    import sm_pkg::*;
#(
    parameter int unsigned STEP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pdn_n,
    input  logic              step_en,
    input  logic              mute_req,
    output logic [STEP_W:0]   level,
    output logic [STEP_W:0]   coef,
    output logic              at_floor
);
    localparam int unsigned LW = STEP_W + 1;
    localparam logic [LW-1:0] FULL = {1'b1, {STEP_W{1'b0}}};
    localparam logic [LW-1:0] ONE  = {{STEP_W{1'b0}}, 1'b1};

    typedef struct packed {
        logic [LW-1:0] level;
    } lvl_t;

    lvl_t      st_d, st_q;
    ramp_dir_e dir;

    always_comb begin
        st_d = st_q;
        dir  = RAMP_HOLD;
        if (step_en) begin
            if (mute_req && st_q.level != FULL) begin
                dir = RAMP_UP;
            end else if (!mute_req && st_q.level != '0) begin
                dir = RAMP_DOWN;
            end
        end
        case (dir)
            RAMP_UP:   st_d.level = st_q.level + ONE;
            RAMP_DOWN: st_d.level = st_q.level - ONE;
            default:   st_d.level = st_q.level;
        endcase
        if (!pdn_n) begin
            st_d.level = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level    = st_q.level;
    assign coef     = FULL - st_q.level;
    assign at_floor = (st_q.level == FULL);
endmodule

// File: rtl/sm_chan_scale.sv
module sm_chan_scale #(
    parameter int unsigned DW     = 24,
    parameter int unsigned STEP_W = 10
) (
    input  logic [DW-1:0]     sample,
    input  logic [STEP_W:0]   coef,
    output logic [DW-1:0]     scaled
);
    localparam int unsigned PW = DW + STEP_W + 2;
    localparam logic signed [PW-1:0] HALF =
        {{(PW-STEP_W){1'b0}}, 1'b1, {(STEP_W-1){1'b0}}};
    localparam logic signed [PW-1:0] MAXV =
        {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV =
        {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [PW-1:0] x_ext, c_ext, prod, rnd, shifted;

    always_comb begin
        x_ext   = $signed({{(PW-DW){sample[DW-1]}}, sample});
        c_ext   = $signed({{(PW-STEP_W-1){1'b0}}, coef});
        prod    = x_ext * c_ext;
        rnd     = prod + HALF;
        shifted = rnd >>> STEP_W;
        if (shifted > MAXV) begin
            scaled = MAXV[DW-1:0];
        end else if (shifted < MINV) begin
            scaled = MINV[DW-1:0];
        end else begin
            scaled = shifted[DW-1:0];
        end
    end
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
    import sm_pkg::*;
#(
    parameter int unsigned DW     = 24,
    parameter int unsigned STEP_W = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pdn_n,
    input  logic          mute_req,
    input  logic          in_valid,
    input  logic [DW-1:0] in_left,
    input  logic [DW-1:0] in_right,
    output logic          out_valid,
    output logic [DW-1:0] out_left,
    output logic [DW-1:0] out_right,
    output logic          muted
);
    typedef struct packed {
        logic                    valid;
        logic [NCH-1:0][DW-1:0]  smp;
    } out_t;

    out_t                   o_d, o_q;
    logic                   take;
    logic [STEP_W:0]        level;
    logic [STEP_W:0]        coef;
    logic [NCH-1:0][DW-1:0] chan_in;
    logic [NCH-1:0][DW-1:0] chan_out;

    assign take       = in_valid && pdn_n;
    assign chan_in[0] = in_left;
    assign chan_in[1] = in_right;

    sm_level_ctrl #(.STEP_W(STEP_W)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .pdn_n    (pdn_n),
        .step_en  (take),
        .mute_req (mute_req),
        .level    (level),
        .coef     (coef),
        .at_floor (muted)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        sm_chan_scale #(.DW(DW), .STEP_W(STEP_W)) u_scale (
            .sample (chan_in[ch]),
            .coef   (coef),
            .scaled (chan_out[ch])
        );
    end

    always_comb begin
        o_d       = o_q;
        o_d.valid = take;
        if (!pdn_n) begin
            o_d.smp = '0;
        end else if (take) begin
            o_d.smp = chan_out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.valid;
    assign out_left  = o_q.smp[0];
    assign out_right = o_q.smp[1];
endmodule

// File: rtl/soft_mute_ramp_chk.sv
module soft_mute_ramp_chk #(
    parameter int unsigned DW     = 24,
    parameter int unsigned STEP_W = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pdn_n,
    input logic          in_valid,
    input logic          out_valid,
    input logic [DW-1:0] out_left,
    input logic [DW-1:0] out_right,
    input logic          muted,
    input logic [STEP_W:0] level
);
    localparam int FULL_I = 1 << STEP_W;

    // R8: no accepted sample, no level change
    a_r8_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(in_valid) && $past(pdn_n)) |-> $stable(level));

    // R3 / R6: at most one step per accepted sample
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && $past(pdn_n)) |->
            (int'(level) == int'($past(level)) ||
             int'(level) == int'($past(level)) + 1 ||
             int'(level) + 1 == int'($past(level))));

    // R9: power-down clears outputs and level
    a_r9_pdn_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_n |=> (out_left == '0 && out_right == '0 && !out_valid && level == '0));

    // R4: sample produced at full attenuation is zero
    a_r4_zero_at_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && int'($past(level)) == FULL_I) |->
            (out_left == '0 && out_right == '0));

    // R2: output strobe follows accepted input by one cycle
    a_r2_strobe_delay: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid && pdn_n));

    // R3: muted flag matches full attenuation
    a_r3_flag_match: assert property (@(posedge clk) disable iff (!rst_n)
        muted == (int'(level) == FULL_I));
endmodule

bind soft_mute_ramp soft_mute_ramp_chk #(.DW(DW), .STEP_W(STEP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pdn_n     (pdn_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right),
    .muted     (muted),
    .level     (level)
);

// File: tb/sim_soft_mute_ramp.sv
`timescale 1ns/1ps
module sim_soft_mute_ramp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pdn_n = 1'b1;
    logic        mute_req = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_left = '0;
    logic [23:0] in_right = '0;
    logic        out_valid;
    logic [23:0] out_left;
    logic [23:0] out_right;
    logic        muted;

    int  n_chk = 0;
    int  n_fail = 0;
    int  lvl_m = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    soft_mute_ramp u0 (
        .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .mute_req(mute_req),
        .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
        .muted(muted)
    );

    function automatic int s24(int v);
        logic [23:0] t;
        t = v[23:0];
        return int'($signed(t));
    endfunction

    function automatic int expect_val(int x, int a);
        longint p;
        p = longint'(x) * longint'(1024 - a) + 64'sd512;
        p = p >>> 10;
        if (p > 64'sd8388607) p = 64'sd8388607;
        if (p < -64'sd8388608) p = -64'sd8388608;
        return int'(p);
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one accepted sample; compares against model, then steps the model level
    task automatic send(int l, int r, bit m, string req);
        int el, er;
        @(negedge clk);
        in_left = l[23:0]; in_right = r[23:0]; mute_req = m; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        el = expect_val(s24(l), lvl_m);
        er = expect_val(s24(r), lvl_m);
        chk(out_valid == 1'b1, req, "out_valid", out_valid, 1);
        chk(s24(int'(out_left)) == el, req, "left", s24(int'(out_left)), el);
        chk(s24(int'(out_right)) == er, req, "right", s24(int'(out_right)), er);
        if (m && lvl_m < 1024) lvl_m++;
        else if (!m && lvl_m > 0) lvl_m--;
        chk(muted == (lvl_m == 1024), req, "muted", muted, lvl_m == 1024);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_left == 0 && out_right == 0, "R1", "outputs in reset", out_left, 0);
        chk(!out_valid && !muted, "R1", "strobe/flag in reset", {out_valid, muted}, 0);
        rst_n = 1'b1;
        lvl_m = 0;
        @(negedge clk);
    endtask

    task automatic t_unity;
        send(24'h7FFFFF, 24'h800000, 1'b0, "R2");
        send(24'h000001, 24'hFFFFFF, 1'b0, "R2");
        send(24'h123456, 24'hABCDEF, 1'b0, "R2");
        @(negedge clk);
        chk(out_valid == 1'b0, "R2", "strobe one cycle", out_valid, 0);
    endtask

    task automatic t_full_down;
        for (int i = 0; i < 1024; i++) begin
            if (i % 2 == 0) send(24'h7FFFFF, 24'h800000, 1'b1, "R5");
            else send(s24(i * 104729), s24(i * 7919 + 12345), 1'b1, "R3");
        end
        chk(muted == 1'b1 && lvl_m == 1024, "R3", "muted after 1024", muted, 1);
        send(24'h7FFFFF, 24'h800000, 1'b1, "R4");
        chk(out_left == 0 && out_right == 0, "R4", "zero at floor", out_left, 0);
    endtask

    task automatic t_full_up;
        for (int i = 0; i < 1024; i++)
            send(s24(i * 55511 + 3), s24(-i * 3301), 1'b0, "R6");
        chk(lvl_m == 0 && muted == 1'b0, "R6", "back to unity", muted, 0);
        send(24'h654321, 24'h9ABCDE, 1'b0, "R6");
        chk(out_left == 24'h654321, "R6", "unity after release", out_left, 24'h654321);
    endtask

    task automatic t_reverse;
        for (int i = 0; i < 300; i++) send(24'h400000, 24'hC00000, 1'b1, "R7");
        for (int i = 0; i < 300; i++) send(24'h400000, 24'hC00000, 1'b0, "R7");
        send(24'h400000, 24'hC00000, 1'b0, "R7");
        chk(out_left == 24'h400000, "R7", "unity after reversal", out_left, 24'h400000);
    endtask

    task automatic t_idle_hold;
        logic [23:0] held;
        for (int i = 0; i < 100; i++) send(24'h2AAAAA, 24'h155555, 1'b1, "R8");
        held = out_left;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R8", "no strobe idle", out_valid, 0);
            chk(out_left == held, "R8", "output held", out_left, held);
        end
        send(24'h2AAAAA, 24'h155555, 1'b1, "R8");
        for (int i = 0; i < 101; i++) send(24'h2AAAAA, 24'h155555, 1'b0, "R8");
    endtask

    task automatic t_pdn;
        for (int i = 0; i < 500; i++) send(24'h7FFFFF, 24'h7FFFFF, 1'b1, "R9");
        @(negedge clk);
        pdn_n = 1'b0; in_valid = 1'b1; in_left = 24'h7FFFFF; in_right = 24'h7FFFFF;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(out_left == 0 && out_right == 0, "R9", "zero in power-down", out_left, 0);
            chk(out_valid == 1'b0 && muted == 1'b0, "R9", "strobe/flag in power-down", out_valid, 0);
        end
        in_valid = 1'b0; pdn_n = 1'b1;
        lvl_m = 0;
        send(24'h345678, 24'hCBA987, 1'b0, "R9");
        chk(out_left == 24'h345678, "R9", "unity after power-down", out_left, 24'h345678);
    endtask

    task automatic t_channels;
        for (int i = 0; i < 600; i++)
            send(24'h7FFFFF, 24'h000100 + i, 1'b1, "R10");
        for (int i = 0; i < 600; i++)
            send(24'h000100 + i, 24'h800000, 1'b0, "R10");
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_unity();
        t_full_down();
        t_full_up();
        t_reverse();
        t_idle_hold();
        t_pdn();
        t_channels();
        finish_run();
    end
endmodule